// File: doc/BRIEF.md
# Hot Basic Block Profiler

This block watches the stream of program counter values that an in-order core commits. It finds control transfers by checking whether each committed PC follows the previous one in sequence, and it does not decode any opcodes. Each branch or jump target it sees is recorded in a small fully associative table, and every entry carries a saturating execution counter. Any entry whose count is strictly above a programmable threshold is reported as hot. Software, or a later training step, can read back the address, count and hot bit of any slot through a combinational read port.

Control is a two-state machine. In `ST_COLD` no previous PC is held. The first strobe moves the machine to `ST_WATCH`, and that strobe only loads the previous-PC register. In `ST_WATCH` each strobe is classified as sequential or as a transfer, and a transfer produces one table action: bump an existing entry, insert a new one, or drop the target. A synchronous clear sends either state back to `ST_COLD`. `ST_WATCH` stays in `ST_WATCH` on every other strobe.

Top module: `hbb_profiler`

## Requirements
- R1: After reset every table slot is invalid, `overflow` is 0 and `hot_flags` is all zeros.
- R2: The first strobed PC after reset or after a clear only becomes the previous PC. It never changes the table.
- R3: A strobed PC equal to the previous PC plus 8 is sequential and leaves the table unchanged. PC values presented while `pc_valid` is low are ignored and do not replace the previous PC.
- R4: Any strobed PC other than previous PC plus 8 is a transfer. If its address is not in the table, it is written into the lowest-numbered free slot with count 1, and one address never occupies two slots.
- R5: A transfer whose target matches a valid slot adds 1 to that slot's count, and the result is visible on the next cycle.
- R6: A slot is hot exactly when it is valid and its count is strictly greater than `threshold`. A count equal to the threshold is not hot, and a change of `threshold` takes effect combinationally.
- R7: A count never wraps. It stops at the all-ones value of the counter width.
- R8: When all slots are valid, a new target is dropped and `overflow` is set and stays set until a clear. Hits on existing slots still count.
- R9: `clear` empties all slots, resets `overflow` and returns the machine to `ST_COLD` on the next edge. It takes priority over a strobe in the same cycle.
- R10: `rd_idx` selects a slot combinationally, and `rd_valid`, `rd_addr`, `rd_count` and `rd_hot` report that slot's contents.
- R11: Bit i of `hot_flags` is the hot status of slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_valid | input | 1 | Strobe marking `pc` as a committed PC |
| pc | input | ADDR_W | Committed program counter |
| threshold | input | CNT_W | Hotness threshold, 100 in normal use |
| clear | input | 1 | Synchronous table and state clear |
| rd_idx | input | IDX_W | Slot selected for read-back |
| rd_valid | output | 1 | Selected slot holds an address |
| rd_addr | output | ADDR_W | Start address in the selected slot |
| rd_count | output | CNT_W | Execution count of the selected slot |
| rd_hot | output | 1 | Selected slot is hot |
| hot_flags | output | ENTRIES | Hot status of every slot |
| overflow | output | 1 | A target was dropped because the table was full |

## Verification
The bench runs the profiler with an 8-bit counter so that it can reach saturation quickly. A design that wrapped the count would show a small value after 300 extra hits instead of 255. The bench sets the count exactly equal to the threshold, where a design using `>=` would flag the slot hot too early. It fills all sixteen slots and then sends one more target: a design that overwrote a slot would lose slot 15's address, and one without a sticky flag would drop `overflow` again on the next hit. It also asserts clear and a strobe in the same cycle and then sends the first PC after clear. A design that let the strobe win, or that kept the old previous PC, would create an entry that should not exist.

// File: rtl/hbb_pkg.sv
`timescale 1ns/1ps
package hbb_pkg;

    // Control state of the profiler
    typedef enum logic [0:0] {
        ST_COLD  = 1'b0,   // no previous PC captured yet
        ST_WATCH = 1'b1    // previous PC held, classifying each strobe
    } prof_state_e;

    // Table action chosen for one strobe
    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_BUMP   = 2'd1,
        ACT_INSERT = 2'd2,
        ACT_DROP   = 2'd3
    } tbl_act_e;

endpackage

// File: rtl/hbb_flow_detect.sv
`timescale 1ns/1ps
// Holds the last committed PC and reports whether the present PC breaks
// the sequential stride.
module hbb_flow_detect #(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc,
    output logic              is_jump
);

    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] prev_q;
    logic [ADDR_W-1:0] next_seq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else if (load) begin
            prev_q <= pc;
        end
    end

    assign next_seq = prev_q + STRIDE;
    assign is_jump  = (pc != next_seq);

endmodule

// File: rtl/hbb_lookup.sv
`timescale 1ns/1ps
// Associative search over the table: match vector, lowest matching slot,
// lowest free slot and a full indication.
module hbb_lookup #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             valid,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] addrs,
    input  logic [ADDR_W-1:0]              key,
    output logic [ENTRIES-1:0]             match_vec,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           full,
    output logic [IDX_W-1:0]               free_idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (addrs[g] == key);
    end

    assign hit  = |match_vec;
    assign full = &valid;

    // Lowest index wins: scan downward so the last assignment is the lowest.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/hbb_table.sv
`timescale 1ns/1ps
// Storage for the start addresses and their saturating counters.
module hbb_table #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           ins_en,
    input  logic [IDX_W-1:0]               ins_idx,
    input  logic [ADDR_W-1:0]              ins_addr,
    input  logic                           bump_en,
    input  logic [IDX_W-1:0]               bump_idx,
    output logic [ENTRIES-1:0]             valid_q,
    output logic [ENTRIES-1:0][ADDR_W-1:0] addr_q,
    output logic [ENTRIES-1:0][CNT_W-1:0]  cnt_q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel_ins;
        logic sel_bump;

        assign sel_ins  = ins_en  && (ins_idx  == IDX_W'(g));
        assign sel_bump = bump_en && (bump_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                cnt_q[g]   <= '0;
            end else if (clear) begin
                valid_q[g] <= 1'b0;
                addr_q[g]  <= '0;
                cnt_q[g]   <= '0;
            end else if (sel_ins) begin
                valid_q[g] <= 1'b1;
                addr_q[g]  <= ins_addr;
                cnt_q[g]   <= CNT_ONE;
            end else if (sel_bump && (cnt_q[g] != CNT_MAX)) begin
                cnt_q[g]   <= cnt_q[g] + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/hbb_profiler.sv
`timescale 1ns/1ps
// Top level: control state machine, hot compare and read-back mux.
module hbb_profiler #(
    parameter int ADDR_W     = 32,
    parameter int ENTRIES    = 16,
    parameter int CNT_W      = 16,
    parameter int INSN_BYTES = 8,
    localparam int IDX_W     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pc_valid,
    input  logic [ADDR_W-1:0]  pc,
    input  logic [CNT_W-1:0]   threshold,
    input  logic               clear,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_valid,
    output logic [ADDR_W-1:0]  rd_addr,
    output logic [CNT_W-1:0]   rd_count,
    output logic               rd_hot,
    output logic [ENTRIES-1:0] hot_flags,
    output logic               overflow
);

    import hbb_pkg::*;

    prof_state_e state_q, state_d;
    tbl_act_e    act;

    logic                           load_prev;
    logic                           is_jump;
    logic [ENTRIES-1:0]             tbl_valid;
    logic [ENTRIES-1:0][ADDR_W-1:0] tbl_addr;
    logic [ENTRIES-1:0][CNT_W-1:0]  tbl_cnt;
    logic [ENTRIES-1:0]             match_vec;
    logic                           hit;
    logic                           full;
    logic [IDX_W-1:0]               hit_idx;
    logic [IDX_W-1:0]               free_idx;
    logic                           ins_en;
    logic                           bump_en;
    logic                           drop_evt;

    // ---------------- sub-blocks ----------------
    hbb_flow_detect #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_flow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_prev),
        .pc      (pc),
        .is_jump (is_jump)
    );

    hbb_lookup #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES)
    ) u_lookup (
        .valid     (tbl_valid),
        .addrs     (tbl_addr),
        .key       (pc),
        .match_vec (match_vec),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .full      (full),
        .free_idx  (free_idx)
    );

    hbb_table #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (ENTRIES),
        .CNT_W   (CNT_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .ins_en   (ins_en),
        .ins_idx  (free_idx),
        .ins_addr (pc),
        .bump_en  (bump_en),
        .bump_idx (hit_idx),
        .valid_q  (tbl_valid),
        .addr_q   (tbl_addr),
        .cnt_q    (tbl_cnt)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COLD;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state and action ----------------
    always_comb begin
        state_d   = state_q;
        act       = ACT_NONE;
        load_prev = 1'b0;
        if (clear) begin
            state_d = ST_COLD;
        end else if (pc_valid) begin
            load_prev = 1'b1;
            unique case (state_q)
                ST_COLD: begin
                    state_d = ST_WATCH;
                end
                ST_WATCH: begin
                    state_d = ST_WATCH;
                    if (is_jump) begin
                        if (hit) begin
                            act = ACT_BUMP;
                        end else if (full) begin
                            act = ACT_DROP;
                        end else begin
                            act = ACT_INSERT;
                        end
                    end
                end
                default: state_d = ST_COLD;
            endcase
        end
    end

    // ---------------- action decode ----------------
    always_comb begin
        ins_en   = 1'b0;
        bump_en  = 1'b0;
        drop_evt = 1'b0;
        unique case (act)
            ACT_NONE:   ;
            ACT_BUMP:   bump_en  = 1'b1;
            ACT_INSERT: ins_en   = 1'b1;
            ACT_DROP:   drop_evt = 1'b1;
            default:    ;
        endcase
    end

    // Sticky overflow flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (clear) begin
            overflow <= 1'b0;
        end else if (drop_evt) begin
            overflow <= 1'b1;
        end
    end

    // ---------------- hot compare ----------------
    for (genvar g = 0; g < ENTRIES; g++) begin : g_hot
        assign hot_flags[g] = tbl_valid[g] && (tbl_cnt[g] > threshold);
    end

    // ---------------- read-back ----------------
    assign rd_valid = tbl_valid[rd_idx];
    assign rd_addr  = tbl_addr[rd_idx];
    assign rd_count = tbl_cnt[rd_idx];
    assign rd_hot   = hot_flags[rd_idx];

endmodule

// File: rtl/hbb_profiler_checker.sv
`timescale 1ns/1ps
module hbb_profiler_checker #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 16,
    parameter int CNT_W   = 16
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          clear,
    input logic                          pc_valid,
    input hbb_pkg::prof_state_e          state_q,
    input logic [ENTRIES-1:0]            valid_q,
    input logic [ENTRIES-1:0][CNT_W-1:0] cnt_q,
    input logic [ENTRIES-1:0]            match_vec,
    input logic                          overflow,
    input logic [ENTRIES-1:0]            hot_flags
);

    import hbb_pkg::*;

    assert_reset_empty_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (valid_q == '0 && !overflow && hot_flags == '0));

    assert_first_pc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COLD && pc_valid && !clear) |=> ($stable(valid_q) && $stable(cnt_q)));

    assert_unique_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    assert_hot_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((hot_flags & ~valid_q) == '0));

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mono
        assert_count_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !clear |=> (cnt_q[g] >= $past(cnt_q[g])));
    end

    assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0 && !overflow && state_q == ST_COLD));

endmodule

bind hbb_profiler hbb_profiler_checker #(
    .ADDR_W  (ADDR_W),
    .ENTRIES (ENTRIES),
    .CNT_W   (CNT_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (clear),
    .pc_valid  (pc_valid),
    .state_q   (state_q),
    .valid_q   (tbl_valid),
    .cnt_q     (tbl_cnt),
    .match_vec (match_vec),
    .overflow  (overflow),
    .hot_flags (hot_flags)
);

// File: tb/hbb_profiler_test.sv
`timescale 1ns/1ps
module hbb_profiler_test;

    localparam int AW  = 32;
    localparam int NE  = 16;
    localparam int CW  = 8;
    localparam int IW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pc_valid = 1'b0;
    logic [AW-1:0] pc = '0;
    logic [CW-1:0] threshold = 8'd100;
    logic          clear = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_addr;
    logic [CW-1:0] rd_count;
    logic          rd_hot;
    logic [NE-1:0] hot_flags;
    logic          overflow;

    int tests  = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hbb_profiler #(.ADDR_W(AW), .ENTRIES(NE), .CNT_W(CW), .INSN_BYTES(8)) uut (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
        .threshold(threshold), .clear(clear), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_count(rd_count),
        .rd_hot(rd_hot), .hot_flags(hot_flags), .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one committed PC for one cycle; returns at the following negedge.
    task automatic send(input logic [AW-1:0] a);
        @(negedge clk);
        pc_valid = 1'b1;
        pc = a;
        @(negedge clk);
        pc_valid = 1'b0;
    endtask

    task automatic check_slot(input int idx, input bit v, input logic [AW-1:0] a,
                              input logic [CW-1:0] c, input bit h, input string req);
        rd_idx = IW'(idx);
        #1;
        chk(rd_valid == v, {req, " valid (R10)"}, 32'(rd_valid), 32'(v));
        if (v) begin
            chk(rd_addr == a, {req, " addr (R10)"}, rd_addr, a);
            chk(rd_count == c, {req, " count"}, 32'(rd_count), 32'(c));
            chk(rd_hot == h, {req, " hot"}, 32'(rd_hot), 32'(h));
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NE; i++) check_slot(i, 1'b0, '0, '0, 1'b0, "R1 empty");
        chk(overflow == 1'b0, "R1 overflow", 32'(overflow), 0);
        chk(hot_flags == '0, "R1 hot_flags", 32'(hot_flags), 0);
    endtask

    task automatic t_first_seq();
        send(32'h1000);
        check_slot(0, 1'b0, '0, '0, 1'b0, "R2 first pc");
        send(32'h1008);
        send(32'h1010);
        check_slot(0, 1'b0, '0, '0, 1'b0, "R3 sequential");
        @(negedge clk);
        pc = 32'h5000;              // not strobed
        @(negedge clk);
        check_slot(0, 1'b0, '0, '0, 1'b0, "R3 no strobe");
        send(32'h1018);             // still sequential to 0x1010
        check_slot(0, 1'b0, '0, '0, 1'b0, "R3 prev kept");
        send(32'h2000);
        check_slot(0, 1'b1, 32'h2000, 8'd1, 1'b0, "R4 insert");
    endtask

    task automatic t_hit();
        send(32'h2008);
        send(32'h3000);
        check_slot(1, 1'b1, 32'h3000, 8'd1, 1'b0, "R4 lowest free");
        send(32'h2000);
        check_slot(0, 1'b1, 32'h2000, 8'd2, 1'b0, "R5 bump");
    endtask

    task automatic t_hot();
        threshold = 8'd3;
        send(32'h3000);
        send(32'h2000);             // slot0=3 slot1=2
        check_slot(0, 1'b1, 32'h2000, 8'd3, 1'b0, "R6 equal not hot");
        send(32'h3000);
        send(32'h2000);             // slot0=4 slot1=3
        check_slot(0, 1'b1, 32'h2000, 8'd4, 1'b1, "R6 above hot");
        #1;
        chk(hot_flags == 16'h0001, "R11 vector", 32'(hot_flags), 32'h1);
        threshold = 8'd2;
        #1;
        chk(hot_flags == 16'h0003, "R11 R6 new threshold", 32'(hot_flags), 32'h3);
        threshold = 8'd100;
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 300; k++) begin
            send(32'h3000);
            send(32'h2000);
        end
        check_slot(0, 1'b1, 32'h2000, 8'hFF, 1'b1, "R7 saturate 0");
        check_slot(1, 1'b1, 32'h3000, 8'hFF, 1'b1, "R7 saturate 1");
    endtask

    task automatic t_full();
        for (int k = 0; k < 14; k++) send(32'h10000 + 32'(k) * 32'h100);
        #1;
        chk(overflow == 1'b0, "R8 not yet full", 32'(overflow), 0);
        check_slot(15, 1'b1, 32'h10D00, 8'd1, 1'b0, "R4 last slot");
        send(32'h90000);
        #1;
        chk(overflow == 1'b1, "R8 overflow set", 32'(overflow), 1);
        check_slot(15, 1'b1, 32'h10D00, 8'd1, 1'b0, "R8 no overwrite");
        send(32'h10000);
        check_slot(2, 1'b1, 32'h10000, 8'd2, 1'b0, "R8 hit when full");
        chk(overflow == 1'b1, "R8 sticky", 32'(overflow), 1);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clear = 1'b1;
        pc_valid = 1'b1;
        pc = 32'h4444;
        @(negedge clk);
        clear = 1'b0;
        pc_valid = 1'b0;
        for (int i = 0; i < NE; i++) check_slot(i, 1'b0, '0, '0, 1'b0, "R9 emptied");
        chk(overflow == 1'b0, "R9 overflow cleared", 32'(overflow), 0);
        chk(hot_flags == '0, "R9 hot cleared", 32'(hot_flags), 0);
        send(32'h5000);
        check_slot(0, 1'b0, '0, '0, 1'b0, "R9 R2 first after clear");
        send(32'h6000);
        check_slot(0, 1'b1, 32'h6000, 8'd1, 1'b0, "R9 insert after clear");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_seq();
        t_hit();
        t_hot();
        t_saturate();
        t_full();
        t_clear();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            tests++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, errors);
            $finish;
        end
    end

endmodule